// File: doc/BRIEF.md
# Serial Stereo Audio Receiver with Word-Length Adaptation

This block receives the three-wire serial stereo link defined by the I2S convention and acts as its slave. The sender drives a bit clock, a channel-select line and a serial data line. The receiver samples all three with its own system clock and rebuilds the left and right samples at a fixed output width. The sender's word length need not be configured. A short word is padded with zeros below its last bit. A long word keeps its leading bits, and the bits past the output width are dropped.

Each completed stereo pair is put on two parallel output buses together with a strobe one system clock wide. The bus values then hold until the next pair is complete. The block can come out of reset at any point in the serial stream. It collects nothing until it has seen a channel-select change, and it only forms a pair from a left word followed by a right word that were both collected in full.

Top module: `i2s_stereo_rx`

## Requirements
- R1: While reset is asserted and after it is released, `left_o` and `right_o` read zero and `pair_vld_o` is low until the first pair is complete.
- R2: A word sent while `chsel_i` is low is a left sample, and it appears on `left_o`. A word sent while `chsel_i` is high is a right sample, and it appears on `right_o`.
- R3: Data is taken MSB first on rising bit-clock edges. The bit taken at the edge where a `chsel_i` change is first seen is the last bit of the word that is ending. The next bit taken is the MSB of the new word.
- R4: A word shorter than OUT_W bits is placed at the top of the output. Its unused low-order bits read zero.
- R5: A word longer than OUT_W bits keeps its first OUT_W bits, and every later bit is discarded.
- R6: Each completed right word that follows a completed left word raises `pair_vld_o` for exactly one system-clock cycle. In that cycle the outputs carry that left/right pair.
- R7: After reset, a word that started before the first `chsel_i` change seen is discarded. No pair is issued until a full left word and a full right word have been collected.
- R8: `left_o` and `right_o` change only in a cycle where `pair_vld_o` is high. They hold their values while the next frame is being received.
- R9: The sender may change its word length from one frame to the next, and each frame is converted correctly with no setting changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock from the sender |
| chsel_i | input | 1 | Channel select: low = left, high = right |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | OUT_W | Last completed left sample |
| right_o | output | OUT_W | Last completed right sample |
| pair_vld_o | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
The bench builds the block with OUT_W = 24 and two synchronizer stages, and runs a bit clock with eight system clocks per bit. Senders using 16-, 20-, 24- and 32-bit words reach both the zero-fill path and the truncation path, along with the exact-fit case where the bit counter stops exactly at its limit. Word lengths are changed between frames. One run begins from a reset in the middle of a word, which exercises the discard of partial words at start-up.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/srx_edge.sv
module srx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/srx_deser.sv
module srx_deser
  import srx_pkg::*;
#(
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             chsel_i,
  input  logic             sdata_i,
  output logic             done_o,
  output chan_e            chan_o,
  output logic [OUT_W-1:0] word_o
);
  localparam int CW = $clog2(OUT_W + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(OUT_W);

  logic             seen_q, seen_d;
  logic             aligned_q, aligned_d;
  logic             chsel_q, chsel_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [OUT_W-1:0] acc_q, acc_d;
  logic [OUT_W-1:0] acc_ins;
  logic             room;
  logic             flip;

  assign room = (cnt_q < CNT_MAX);
  assign flip = rise_i && seen_q && (chsel_i != chsel_q);

  always_comb begin
    acc_ins = acc_q;
    for (int i = 0; i < OUT_W; i++) begin
      if (room && (cnt_q == CW'(OUT_W - 1 - i))) acc_ins[i] = sdata_i;
    end
  end

  always_comb begin
    seen_d    = seen_q;
    aligned_d = aligned_q;
    chsel_d   = chsel_q;
    cnt_d     = cnt_q;
    acc_d     = acc_q;
    if (rise_i) begin
      seen_d  = 1'b1;
      chsel_d = chsel_i;
      if (flip) begin
        aligned_d = 1'b1;
        cnt_d     = '0;
        acc_d     = '0;
      end else if (room) begin
        cnt_d = cnt_q + 1'b1;
        acc_d = acc_ins;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      aligned_q <= 1'b0;
      chsel_q   <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
    end else begin
      seen_q    <= seen_d;
      aligned_q <= aligned_d;
      chsel_q   <= chsel_d;
      cnt_q     <= cnt_d;
      acc_q     <= acc_d;
    end
  end

  assign done_o = flip && aligned_q;
  assign chan_o = chan_e'(chsel_q);
  assign word_o = acc_ins;

  // R5: the bit counter never passes the output width
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  // R3: a word completes only on a bit-clock rising edge
  p_done_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> rise_i);
  // R3: a channel change restarts collection at the MSB
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (cnt_q == '0));
endmodule

// File: rtl/i2s_stereo_rx.sv
module i2s_stereo_rx
  import srx_pkg::*;
#(
  parameter int OUT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_i,
  input  logic             chsel_i,
  input  logic             sdata_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             pair_vld_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0]  raw_in, syn;
  logic             bclk_rise;
  logic             done;
  chan_e            chan;
  logic [OUT_W-1:0] word;

  logic [OUT_W-1:0] lhold_q, lhold_d;
  logic             lok_q, lok_d;
  logic [OUT_W-1:0] left_q, left_d, right_q, right_d;
  logic             vld_q, vld_d;

  assign raw_in = {sdata_i, chsel_i, bclk_i};

  srx_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn)
  );

  srx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(syn[0]), .rise_o(bclk_rise)
  );

  srx_deser #(.OUT_W(OUT_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .rise_i(bclk_rise), .chsel_i(syn[1]),
    .sdata_i(syn[2]), .done_o(done), .chan_o(chan), .word_o(word)
  );

  always_comb begin
    lhold_d = lhold_q;
    lok_d   = lok_q;
    left_d  = left_q;
    right_d = right_q;
    vld_d   = 1'b0;
    if (done) begin
      if (chan == CH_LEFT) begin
        lhold_d = word;
        lok_d   = 1'b1;
      end else begin
        lok_d = 1'b0;
        if (lok_q) begin
          left_d  = lhold_q;
          right_d = word;
          vld_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lhold_q <= '0;
      lok_q   <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      lhold_q <= lhold_d;
      lok_q   <= lok_d;
      left_q  <= left_d;
      right_q <= right_d;
      vld_q   <= vld_d;
    end
  end

  assign left_o     = left_q;
  assign right_o    = right_q;
  assign pair_vld_o = vld_q;

  // R6: the strobe lasts a single cycle
  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_o |=> !pair_vld_o);
  // R6: the strobe follows the completion of a right word
  p_vld_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_o |-> $past(done && (chan == CH_RIGHT)));
  // R8: the outputs move only together with the strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(left_o) || !$stable(right_o)) |-> pair_vld_o);
endmodule

// File: tb/i2s_stereo_rx_tb.sv
module i2s_stereo_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OW         = 24;
  localparam int HALF       = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bclk, chsel, sdata;
  logic [OW-1:0] left_o, right_o;
  logic          pair_vld_o;

  int n_chk = 0, n_bad = 0;
  int pairs = 0, wide = 0;
  logic prev_vld = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_stereo_rx #(.OUT_W(OW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .chsel_i(chsel),
    .sdata_i(sdata), .left_o(left_o), .right_o(right_o),
    .pair_vld_o(pair_vld_o)
  );

  always @(negedge clk) begin
    if (pair_vld_o) pairs++;
    if (pair_vld_o && prev_vld) wide++;
    prev_vld = pair_vld_o;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] expw(logic [31:0] x, int n);
    logic [31:0] m;
    m = (n >= 32) ? x : (x & ((32'd1 << n) - 1));
    if (n <= OW) return OW'(m << (OW - n));
    return OW'(m >> (n - OW));
  endfunction

  task automatic send_bit(logic ws, logic d);
    @(negedge clk);
    bclk = 1'b0; chsel = ws; sdata = d;
    repeat (HALF - 1) @(negedge clk);
    @(negedge clk);
    bclk = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    bclk = 1'b0; chsel = 1'b1; sdata = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic preamble();
    repeat (3) send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
  endtask

  task automatic send_frame(logic [31:0] l, logic [31:0] r, int n, string req);
    int p0;
    logic [OW-1:0] ol, orr;
    p0 = pairs; ol = left_o; orr = right_o;
    for (int i = n - 1; i >= 1; i--) send_bit(1'b0, l[i]);
    send_bit(1'b1, l[0]);
    check("R8 left hold", 32'(left_o), 32'(ol));
    check("R8 right hold", 32'(right_o), 32'(orr));
    for (int i = n - 1; i >= 1; i--) send_bit(1'b1, r[i]);
    send_bit(1'b0, r[0]);
    repeat (10) @(negedge clk);
    check({"R6 one pair ", req}, 32'(pairs - p0), 32'd1);
    check({"R2 left ", req}, 32'(left_o), 32'(expw(l, n)));
    check({"R2 right ", req}, 32'(right_o), 32'(expw(r, n)));
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 left zero", 32'(left_o), 32'd0);
    check("R1 right zero", 32'(right_o), 32'd0);
    check("R1 strobe low", 32'(pair_vld_o), 32'd0);
  endtask

  task automatic t_exact();   // R3: MSB-first, exact fit
    preamble();
    send_frame(32'hA5C381, 32'h13579B, 24, "R3 24b");
    send_frame(32'h800001, 32'hFFFFFE, 24, "R3 edges");
  endtask

  task automatic t_short();   // R4
    send_frame(32'hBEEF, 32'h1234, 16, "R4 16b");
  endtask

  task automatic t_long();    // R5
    send_frame(32'hDEADBEEF, 32'h0123ABCD, 32, "R5 32b");
  endtask

  task automatic t_mixed();   // R9
    send_frame(32'hF0F0F, 32'h0F0F0, 20, "R9 20b");
    send_frame(32'hCAFEF00D, 32'h89ABCDEF, 32, "R9 32b");
    send_frame(32'h7001, 32'h8002, 16, "R9 16b");
  endtask

  task automatic t_midstart(); // R7
    int p0;
    do_reset();
    p0 = pairs;
    repeat (5) send_bit(1'b0, 1'b1);
    send_bit(1'b1, 1'b1);
    for (int i = 15; i >= 1; i--) send_bit(1'b1, 1'(16'hABCD >> i));
    send_bit(1'b0, 1'b1);
    repeat (10) @(negedge clk);
    check("R7 no pair from partial", 32'(pairs - p0), 32'd0);
    check("R7 right untouched", 32'(right_o), 32'd0);
    send_frame(32'h5A5A, 32'hA5A5, 16, "R7 first full");
  endtask

  initial begin
    t_reset();
    t_exact();
    t_short();
    t_long();
    t_mixed();
    t_midstart();
    check("R6 strobe width", 32'(wide), 32'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule